// File: doc/BRIEF.md
# Token-Sequenced Serial Byte Receiver

This block receives asynchronous serial characters made of one low start bit, a fixed number of data bits (eight by default) and one high stop bit. It does not count with binary counters. When the line falls while the receiver is idle, a single "hot" bit is placed at the head of a short delay chain. That chain advances only on the oversampling tick and releases the bit half a bit period later, at the middle of the start bit. The bit then enters a recirculating ring as long as one full bit period. Each time the bit leaves the ring, that marks the middle of the next bit.

A one-hot slot register records which bit of the character is due. It fills the received byte from the least significant bit up. At the stop bit it stops the hot bit from going round the ring again, so every chain is empty while the receiver waits for the next character. The caller provides one clock, an enable pulse at sixteen times the bit rate, and the raw serial line. The receiver returns the byte, a one-cycle strobe when the byte is good, and a one-cycle framing-error pulse.

Top module: `uart_token_rx`

## Requirements
- R1: While rst_n is low and in the first cycle after reset, rx_strobe and frame_err are 0 and rx_byte is all zeros.
- R2: ser_in passes through two synchronizing flip-flops. A high-to-low change at the synchronizer output starts a character only when no character is in progress.
- R3: The start bit is sampled on the 8th os_tick after the clock edge that started the character (half of OVERSAMPLE). If it reads 1 there, the character is dropped without any strobe or error, and the receiver is idle again.
- R4: Data bits are sampled every 16th os_tick after the start-bit sample. The first sampled bit goes to rx_byte bit 0 and the last goes to bit 7.
- R5: A stop bit sampled as 1 loads rx_byte and raises rx_strobe for exactly one cycle, on the edge after the sampling edge. rx_byte does not change at any other time.
- R6: A stop bit sampled as 0 raises frame_err for one cycle, leaves rx_strobe low and leaves rx_byte unchanged.
- R7: Falling edges on the line while a character is in progress, including inside the data bits, never start a second character and never create a second hot bit.
- R8: rx_strobe and frame_err are never high in the same cycle.
- R9: All timing counts os_tick pulses only. The spacing between ticks may vary from one tick to the next without changing which bits are sampled.
- R10: After the stop-bit sample the receiver is idle at once, so a start edge directly after the stop bit is received as a new character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all state |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_in | input | 1 | Raw asynchronous serial line, idle high |
| os_tick | input | 1 | One-cycle enable at OVERSAMPLE times the bit rate |
| rx_byte | output | DATA_BITS | Last byte received without framing error |
| rx_strobe | output | 1 | One-cycle pulse when rx_byte has been updated |
| frame_err | output | 1 | One-cycle pulse when the stop bit read low |

## Verification
A lost hot bit leaves the receiver waiting forever. It shows as a missing rx_strobe one stop-bit sample after the start edge, about ten bit periods later. A duplicated hot bit, or a bit that stays in the ring after the stop bit, makes an extra strobe or framing error appear within one bit period. A hot bit that is one stage off moves every sample point. The result is a wrong rx_byte or a wrong error flag on the very next character, most clearly when the tick spacing varies. The bench compares all three outputs with a tick-counting reference model on every cycle, so such faults show at the cycle where they first appear.

// File: rtl/uart_token_pkg.sv
package uart_token_pkg;
   localparam int DEF_DATA_BITS  = 8;
   localparam int DEF_OVERSAMPLE = 16;
   localparam int DEF_SYNC       = 2;

   function automatic int half_period(input int oversample);
      return oversample / 2;
   endfunction
endpackage

// File: rtl/uart_token_sync.sv
module uart_token_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_raw,
   output logic line_sync,
   output logic line_fall
);
   logic [STAGES-1:0] pipe;
   logic              prev;

   generate
      for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) pipe[gi] <= 1'b1;
               else        pipe[gi] <= line_raw;
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) pipe[gi] <= 1'b1;
               else        pipe[gi] <= pipe[gi-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= 1'b1;
      else        prev <= pipe[STAGES-1];

   assign line_sync = pipe[STAGES-1];
   assign line_fall = prev & ~pipe[STAGES-1];
endmodule

// File: rtl/uart_token_chain.sv
module uart_token_chain #(
   parameter int STAGES = 8,
   parameter bit RECIRC = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              load,
   input  logic              kill,
   output logic              hit,
   output logic [STAGES-1:0] cells
);
   logic tail;
   logic feed;

   assign tail = cells[STAGES-1];
   assign hit  = step & tail;

   generate
      if (RECIRC) begin : g_ring
         assign feed = tail & ~kill;
      end else begin : g_line
         assign feed = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     cells[0] <= 1'b0;
      else if (load)  cells[0] <= 1'b1;
      else if (step)  cells[0] <= feed;

   generate
      for (genvar gi = 1; gi < STAGES; gi++) begin : g_cell
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)    cells[gi] <= 1'b0;
            else if (step) cells[gi] <= cells[gi-1];
      end
   endgenerate
endmodule

// File: rtl/uart_token_frame.sv
module uart_token_frame #(
   parameter int DW        = 8,
   parameter bit MSB_FIRST = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_sync,
   input  logic          line_fall,
   input  logic          start_hit,
   input  logic          bit_hit,
   output logic          inject,
   output logic          ring_load,
   output logic          ring_kill,
   output logic          busy,
   output logic [DW:0]   slot,
   output logic [DW-1:0] byte_q,
   output logic          good_q,
   output logic          bad_q
);
   logic [DW-1:0] shreg;
   logic [DW-1:0] shifted;
   logic          at_stop;

   generate
      if (MSB_FIRST) begin : g_msb
         assign shifted = {shreg[DW-2:0], line_sync};
      end else begin : g_lsb
         assign shifted = {line_sync, shreg[DW-1:1]};
      end
   endgenerate

   assign at_stop   = slot[DW];
   assign inject    = line_fall & ~busy;
   assign ring_load = start_hit & ~line_sync;
   assign ring_kill = bit_hit & at_stop;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         busy   <= 1'b0;
         slot   <= '0;
         shreg  <= '0;
         byte_q <= '0;
         good_q <= 1'b0;
         bad_q  <= 1'b0;
      end else begin
         good_q <= 1'b0;
         bad_q  <= 1'b0;
         if (inject) busy <= 1'b1;
         if (start_hit) begin
            if (line_sync) busy <= 1'b0;
            else           slot <= {{DW{1'b0}}, 1'b1};
         end
         if (bit_hit) begin
            if (at_stop) begin
               busy <= 1'b0;
               slot <= '0;
               if (line_sync) begin
                  good_q <= 1'b1;
                  byte_q <= shreg;
               end else begin
                  bad_q <= 1'b1;
               end
            end else begin
               shreg <= shifted;
               slot  <= {slot[DW-1:0], 1'b0};
            end
         end
      end
endmodule

// File: rtl/uart_token_rx.sv
module uart_token_rx
   import uart_token_pkg::*;
#(
   parameter int DATA_BITS   = DEF_DATA_BITS,
   parameter int OVERSAMPLE  = DEF_OVERSAMPLE,
   parameter int SYNC_STAGES = DEF_SYNC,
   parameter bit MSB_FIRST   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ser_in,
   input  logic                 os_tick,
   output logic [DATA_BITS-1:0] rx_byte,
   output logic                 rx_strobe,
   output logic                 frame_err
);
   localparam int HALF = half_period(OVERSAMPLE);

   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("OVERSAMPLE must be even and at least 4");
      end
      if (DATA_BITS < 2) begin : g_bad_dw
         $error("DATA_BITS must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic                  line_sync, line_fall;
   logic                  inject, start_hit, bit_hit;
   logic                  ring_load, ring_kill, busy;
   logic [HALF-1:0]       start_cells;
   logic [OVERSAMPLE-1:0] ring_cells;
   logic [DATA_BITS:0]    slot;

   uart_token_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_raw(ser_in),
      .line_sync(line_sync), .line_fall(line_fall)
   );

   uart_token_chain #(.STAGES(HALF), .RECIRC(1'b0)) u_start (
      .clk(clk), .rst_n(rst_n), .step(os_tick), .load(inject),
      .kill(1'b0), .hit(start_hit), .cells(start_cells)
   );

   uart_token_chain #(.STAGES(OVERSAMPLE), .RECIRC(1'b1)) u_ring (
      .clk(clk), .rst_n(rst_n), .step(os_tick), .load(ring_load),
      .kill(ring_kill), .hit(bit_hit), .cells(ring_cells)
   );

   uart_token_frame #(.DW(DATA_BITS), .MSB_FIRST(MSB_FIRST)) u_frame (
      .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .line_fall(line_fall),
      .start_hit(start_hit), .bit_hit(bit_hit), .inject(inject),
      .ring_load(ring_load), .ring_kill(ring_kill), .busy(busy), .slot(slot),
      .byte_q(rx_byte), .good_q(rx_strobe), .bad_q(frame_err)
   );
endmodule

// File: rtl/uart_token_rx_chk.sv
module uart_token_rx_chk #(
   parameter int DW   = 8,
   parameter int HALF = 8,
   parameter int OS   = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [DW-1:0] rx_byte,
   input logic          rx_strobe,
   input logic          frame_err,
   input logic          busy,
   input logic [HALF-1:0] start_cells,
   input logic [OS-1:0] ring_cells,
   input logic [DW:0]   slot
);
   // R8
   excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_strobe && frame_err));
   // R5
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> !rx_strobe);
   // R6
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> !frame_err);
   // R6
   err_keeps_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> $stable(rx_byte));
   // R5
   byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_strobe |-> $stable(rx_byte));
   // R7
   single_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({start_cells, ring_cells}) <= 1);
   // R7
   single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot));
   // R10
   idle_cold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ring_cells == '0 && slot == '0));
endmodule

bind uart_token_rx uart_token_rx_chk #(
   .DW(DATA_BITS), .HALF(HALF), .OS(OVERSAMPLE)
) i_chk (
   .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_strobe(rx_strobe),
   .frame_err(frame_err), .busy(busy), .start_cells(start_cells),
   .ring_cells(ring_cells), .slot(slot)
);

// File: tb/test_uart_token_rx.sv
module test_uart_token_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_in = 1'b1;
   logic       os_tick = 1'b0;
   logic [7:0] rx_byte;
   logic       rx_strobe, frame_err;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int n_good = 0;
   int n_bad  = 0;

   always #5 clk = ~clk;

   uart_token_rx i_uart_token_rx (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .os_tick(os_tick),
      .rx_byte(rx_byte), .rx_strobe(rx_strobe), .frame_err(frame_err)
   );

   // tick generator: fixed or varying spacing
   bit jitter = 1'b0;
   int gap_cnt = 0;
   logic [7:0] lfsr = 8'h5A;
   always @(negedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (gap_cnt == 0) begin
         os_tick <= 1'b1;
         gap_cnt <= jitter ? (2 + int'(lfsr[2:0]) % 6) - 1 : 3;
      end else begin
         os_tick <= 1'b0;
         gap_cnt <= gap_cnt - 1;
      end
   end

   // behavioural reference model
   int         m_mode = 0;
   int         m_cnt = 0;
   int         m_bit = 0;
   bit         m_q1 = 1, m_q2 = 1, m_prev = 1;
   logic [7:0] m_acc = '0;
   logic [7:0] exp_byte = '0;
   bit         exp_strobe = 0, exp_err = 0;

   always @(posedge clk) begin
      bit line, fall;
      if (!rst_n) begin
         m_mode = 0; m_cnt = 0; m_bit = 0;
         m_q1 = 1; m_q2 = 1; m_prev = 1;
         exp_byte = '0; exp_strobe = 0; exp_err = 0;
      end else begin
         line = m_q2;
         fall = m_prev & ~m_q2;
         m_prev = m_q2; m_q2 = m_q1; m_q1 = ser_in;
         exp_strobe = 0; exp_err = 0;
         case (m_mode)
            0: if (fall) begin m_mode = 1; m_cnt = 0; end
            1: if (os_tick) begin
                  m_cnt++;
                  if (m_cnt == 8) begin
                     if (!line) begin m_mode = 2; m_cnt = 0; m_bit = 0; end
                     else m_mode = 0;
                  end
               end
            default: if (os_tick) begin
                  m_cnt++;
                  if (m_cnt == 16) begin
                     m_cnt = 0;
                     if (m_bit < 8) begin m_acc[m_bit] = line; m_bit++; end
                     else begin
                        m_mode = 0;
                        if (line) begin exp_strobe = 1; exp_byte = m_acc; end
                        else exp_err = 1;
                     end
                  end
               end
         endcase
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      cycles++;
      if (rst_n && cycles > 2) begin
         check(rx_strobe == exp_strobe, "R5 strobe", rx_strobe, exp_strobe);
         check(frame_err == exp_err, "R6 frame_err", frame_err, exp_err);
         check(rx_byte == exp_byte, "R4 byte", rx_byte, exp_byte);
         check(!(rx_strobe && frame_err), "R8 exclusive", {rx_strobe, frame_err}, 0);
         if (rx_strobe) n_good++;
         if (frame_err) n_bad++;
      end
   end

   task automatic wait_ticks(input int n);
      int k = 0;
      while (k < n) begin
         @(negedge clk);
         if (os_tick) k++;
      end
   endtask

   task automatic send(input logic [7:0] b, input bit stop, input int idle);
      ser_in = 1'b0;
      wait_ticks(16);
      for (int i = 0; i < 8; i++) begin
         ser_in = b[i];
         wait_ticks(16);
      end
      ser_in = stop;
      wait_ticks(16);
      ser_in = 1'b1;
      wait_ticks(idle);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      int g0, b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(rx_strobe == 0, "R1 strobe in reset", rx_strobe, 0);
      check(frame_err == 0, "R1 err in reset", frame_err, 0);
      check(rx_byte == 0, "R1 byte in reset", rx_byte, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(rx_strobe == 0 && frame_err == 0 && rx_byte == 0, "R1 after reset",
            {rx_strobe, frame_err, rx_byte}, 0);
      wait_ticks(20);

      // R4 R7: alternating bits give edges inside the frame
      send(8'h55, 1, 20);
      check(rx_byte == 8'h55, "R4 R7 byte 55", rx_byte, 8'h55);
      send(8'hA3, 1, 20);
      check(rx_byte == 8'hA3, "R4 LSB first A3", rx_byte, 8'hA3);
      send(8'h00, 1, 20);
      check(rx_byte == 8'h00, "R4 byte 00", rx_byte, 8'h00);
      send(8'hFF, 1, 20);
      check(rx_byte == 8'hFF, "R4 byte FF", rx_byte, 8'hFF);

      // R6 framing error keeps previous byte
      b0 = n_bad;
      send(8'h3C, 0, 20);
      check(n_bad == b0 + 1, "R6 error pulse count", n_bad, b0 + 1);
      check(rx_byte == 8'hFF, "R6 byte unchanged", rx_byte, 8'hFF);

      // R3 false start: short low pulse
      g0 = n_good; b0 = n_bad;
      ser_in = 1'b0;
      wait_ticks(3);
      ser_in = 1'b1;
      wait_ticks(200);
      check(n_good == g0 && n_bad == b0, "R3 false start ignored", n_good - g0, 0);
      send(8'h81, 1, 10);
      check(rx_byte == 8'h81, "R3 R2 receive after abandon", rx_byte, 8'h81);

      // R10 back-to-back frames with no idle time
      g0 = n_good;
      send(8'h12, 1, 0);
      send(8'h34, 1, 0);
      send(8'hC7, 1, 10);
      check(n_good == g0 + 3, "R10 back-to-back count", n_good, g0 + 3);
      check(rx_byte == 8'hC7, "R10 last byte", rx_byte, 8'hC7);

      // R9 varying tick spacing
      jitter = 1'b1;
      wait_ticks(5);
      send(8'h6E, 1, 20);
      check(rx_byte == 8'h6E, "R9 jittered ticks", rx_byte, 8'h6E);
      send(8'hB5, 1, 20);
      check(rx_byte == 8'hB5, "R9 R2 jittered ticks", rx_byte, 8'hB5);
      b0 = n_bad;
      send(8'h09, 0, 20);
      check(n_bad == b0 + 1, "R9 R6 jittered error", n_bad, b0 + 1);
      summary();
   end

   initial begin
      #1;
      while (cycles < 150000) @(negedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
   end
endmodule